// File: doc/BRIEF.md
# Serial Programming Target

This block is the device end of a serial in-system programming link. A host clocks four-byte instructions in on `sck`/`mosi`. The block answers on `miso`. Both serial lines are oversampled in the system clock domain, so `sck` must run much slower than `clk`.

Every instruction has four bytes: an opcode, a high address byte, a low address byte and a data byte. Nothing takes effect until an enable instruction has been received in correct bit alignment.

Once the link is enabled, the host can do the following:
- Fill a page buffer of 16-bit words one byte at a time.
- Commit the buffer to a flash page. The block streams the page out of a simple write port.
- Write single EEPROM bytes.
- Read flash words. The block issues a one-cycle read request to a synchronous memory and returns the selected byte in the fourth byte slot.

After a commit, a busy window blocks further commits. Dropping the session input clears framing and the enable state, and it is the only way to recover lost bit alignment.

Top module: `spi_prog_target`

## Requirements
- R1: While `rst` is high or `sess_en` is low, the block clears its bit counter, its byte counter, its enable state and its pending low-byte marker, and it drives `miso` to 0. After `rst`, `busy` and `mem_wr` are 0.
- R2: `mosi` is sampled on rising edges of `sck`, most significant bit first. `miso` changes only after falling edges of `sck`, most significant bit first.
- R3: Instructions are exactly 32 bits long, and all four bytes are always consumed. `miso` sends 0x00 during the first byte of every instruction. During the second and third bytes it sends the previously received byte, so the 0x53 of an enable instruction comes back during its third byte.
- R4: Opcode 0xAC with second byte 0x53 enables the link. An opcode of 0xAC with any other second byte does not enable it. While the link is not enabled, no instruction writes memory or issues a read, and the fourth `miso` byte echoes the third received byte.
- R5: If the host sends a stray bit, every later instruction stays misaligned and has no effect until `sess_en` is pulsed low.
- R6: Opcode 0x40 writes the data byte into the low byte of the buffer word at offset `addr[6:0]`, where addr = {byte2, byte3}. It also marks that offset as having a pending low byte.
- R7: Opcode 0x48 writes the high byte of buffer word `addr[6:0]` only when the most recent page-load instruction was a 0x40 to the same offset. Otherwise the high byte is dropped. Either way, the pending marker is cleared.
- R8: Opcode 0x4C commits the page with number `addr[15:7]`. It emits 128 flash write strobes on consecutive cycles, with `mem_sel`=0. The strobes carry addresses page*128 up to page*128+127 in ascending order, each with its buffered word.
- R9: Opcode 0xC0 emits one write strobe with `mem_sel`=1, address addr and data {8'h00, byte4}. The new byte replaces the old value completely.
- R10: Opcodes 0x20 and 0x28 issue a one-cycle `rd_en` with `rd_addr` = addr after the third byte. The fourth `miso` byte is then the low byte (0x20) or the high byte (0x28) of `rd_data`.
- R11: `busy` stays high for exactly 128+BUSY_CYC cycles after a page commit and 1+BUSY_CYC cycles after an EEPROM write. While `busy` is high, commit instructions (0x4C, 0xC0) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_en | input | 1 | Programming session active; low clears framing and enable |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| busy | output | 1 | Commit in progress; commits ignored |
| mem_wr | output | 1 | Memory write strobe |
| mem_sel | output | 1 | 0 = flash word, 1 = EEPROM byte |
| mem_addr | output | 16 | Write address (word or byte) |
| mem_wdata | output | 16 | Write data |
| rd_en | output | 1 | One-cycle flash read request |
| rd_addr | output | 16 | Flash read word address |
| rd_data | input | 16 | Flash read data, valid the cycle after rd_en |

## Verification
A wrong framing count shows up within one instruction. The echoed bytes on `miso` move to the wrong slots, and the enable echo of 0x53 is missing. A wrong enable or pending-low state only shows at the next commit: the streamed page carries the wrong high bytes, or an ignored commit produces strobes. Buffer corruption is exposed by sweeping all 128 offsets and comparing every streamed word. The busy window is measured cycle-exactly and is probed with commits issued inside it.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;

    localparam logic [7:0] OP_ENABLE  = 8'hAC;
    localparam logic [7:0] OP_LOAD_LO = 8'h40;
    localparam logic [7:0] OP_LOAD_HI = 8'h48;
    localparam logic [7:0] OP_PAGE_WR = 8'h4C;
    localparam logic [7:0] OP_EE_WR   = 8'hC0;
    localparam logic [7:0] OP_RD_LO   = 8'h20;
    localparam logic [7:0] OP_RD_HI   = 8'h28;
    localparam logic [7:0] SYNC_BYTE  = 8'h53;

    localparam int ADDR_W = 16;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } word_t;

    function automatic logic is_read(input logic [7:0] op);
        return (op == OP_RD_LO) || (op == OP_RD_HI);
    endfunction

endpackage

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       sess_en,
    input  logic       sck,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       sck_fall,
    output logic       byte_done,
    output logic [1:0] done_idx,
    output logic [1:0] byte_idx,
    output logic [7:0] rx_byte
);
    logic [2:0] sck_sync;
    logic [1:0] mosi_sync;
    logic       sck_rise;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic [7:0] tx_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync  <= '0;
            mosi_sync <= '0;
        end else begin
            sck_sync  <= {sck_sync[1:0], sck};
            mosi_sync <= {mosi_sync[0], mosi};
        end
    end

    assign sck_rise = sck_sync[1] & ~sck_sync[2];
    assign sck_fall = ~sck_sync[1] & sck_sync[2];

    always_ff @(posedge clk) begin
        if (rst || !sess_en) begin
            bit_cnt   <= '0;
            byte_idx  <= '0;
            done_idx  <= '0;
            byte_done <= 1'b0;
            shreg     <= '0;
            rx_byte   <= '0;
            tx_reg    <= '0;
        end else begin
            byte_done <= 1'b0;
            if (sck_rise) begin
                shreg   <= {shreg[5:0], mosi_sync[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_byte   <= {shreg, mosi_sync[1]};
                    byte_done <= 1'b1;
                    done_idx  <= byte_idx;
                    byte_idx  <= byte_idx + 2'd1;
                end
            end
            if (sck_fall) begin
                if (bit_cnt == 3'd0)
                    tx_reg <= tx_byte;
                else
                    tx_reg <= {tx_reg[6:0], 1'b0};
            end
        end
    end

    assign miso = tx_reg[7];

endmodule

// File: rtl/spi_prog_decoder.sv
module spi_prog_decoder
    import spi_prog_pkg::*;
#(
    parameter int PAGE_WORDS = 128,
    localparam int OFF_W  = $clog2(PAGE_WORDS),
    localparam int PAGE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sess_en,
    input  logic              byte_done,
    input  logic [1:0]        done_idx,
    input  logic [1:0]        byte_idx,
    input  logic [7:0]        rx_byte,
    input  logic [15:0]       rd_data,
    input  logic              busy,
    input  logic [OFF_W-1:0]  stream_idx,
    output logic [7:0]        tx_byte,
    output logic              rd_en,
    output logic [15:0]       rd_addr,
    output logic              pw_go,
    output logic [PAGE_W-1:0] pw_page,
    output logic              ee_go,
    output logic [15:0]       ee_addr,
    output logic [7:0]        ee_data,
    output word_t             stream_word
);
    logic [7:0]       op, a_hi, a_lo;
    logic             enabled, lo_pend, rd_ok, rd_hi;
    logic [OFF_W-1:0] lo_off, cur_off;
    logic             exec, do_lo, do_hi;
    word_t            pbuf [PAGE_WORDS];

    assign cur_off = a_lo[OFF_W-1:0];
    assign exec    = byte_done && (done_idx == 2'd3);
    assign do_lo   = exec && enabled && (op == OP_LOAD_LO);
    assign do_hi   = exec && enabled && (op == OP_LOAD_HI) && lo_pend && (lo_off == cur_off);
    assign pw_go   = exec && enabled && (op == OP_PAGE_WR) && !busy;
    assign ee_go   = exec && enabled && (op == OP_EE_WR) && !busy;
    assign pw_page = {a_hi, a_lo}[ADDR_W-1:OFF_W];
    assign ee_addr = {a_hi, a_lo};
    assign ee_data = rx_byte;

    always_ff @(posedge clk) begin
        if (rst || !sess_en) begin
            op      <= '0;
            a_hi    <= '0;
            a_lo    <= '0;
            enabled <= 1'b0;
            lo_pend <= 1'b0;
            lo_off  <= '0;
            rd_ok   <= 1'b0;
            rd_hi   <= 1'b0;
            rd_en   <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_en <= 1'b0;
            if (byte_done) begin
                case (done_idx)
                    2'd0: op   <= rx_byte;
                    2'd1: a_hi <= rx_byte;
                    2'd2: begin
                        a_lo <= rx_byte;
                        if (enabled && is_read(op)) begin
                            rd_en   <= 1'b1;
                            rd_addr <= {a_hi, rx_byte};
                            rd_ok   <= 1'b1;
                            rd_hi   <= (op == OP_RD_HI);
                        end
                    end
                    default: begin
                        rd_ok <= 1'b0;
                        if (op == OP_ENABLE && a_hi == SYNC_BYTE)
                            enabled <= 1'b1;
                        if (do_lo) begin
                            lo_pend <= 1'b1;
                            lo_off  <= cur_off;
                        end
                        if (enabled && op == OP_LOAD_HI)
                            lo_pend <= 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_lo) pbuf[cur_off].lo <= rx_byte;
        if (do_hi) pbuf[cur_off].hi <= rx_byte;
    end

    assign stream_word = pbuf[stream_idx];

    always_comb begin
        if (byte_idx == 2'd0)
            tx_byte = 8'h00;
        else if (byte_idx == 2'd3 && rd_ok)
            tx_byte = rd_hi ? rd_data[15:8] : rd_data[7:0];
        else
            tx_byte = rx_byte;
    end

endmodule

// File: rtl/spi_prog_commit.sv
module spi_prog_commit
    import spi_prog_pkg::*;
#(
    parameter int PAGE_WORDS = 128,
    parameter int BUSY_CYC   = 16,
    localparam int OFF_W  = $clog2(PAGE_WORDS),
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int HOLD_W = $clog2(BUSY_CYC + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pw_go,
    input  logic [PAGE_W-1:0] pw_page,
    input  logic              ee_go,
    input  logic [15:0]       ee_addr,
    input  logic [7:0]        ee_data,
    input  word_t             stream_word,
    output logic [OFF_W-1:0]  stream_idx,
    output logic              busy,
    output logic              mem_wr,
    output logic              mem_sel,
    output logic [15:0]       mem_addr,
    output logic [15:0]       mem_wdata
);
    localparam logic [OFF_W-1:0]  LAST_IDX = OFF_W'(PAGE_WORDS - 1);
    localparam logic [HOLD_W-1:0] HOLD_LD  = HOLD_W'(BUSY_CYC);

    logic              stream_on, ee_pend;
    logic [PAGE_W-1:0] page;
    logic [15:0]       ee_a;
    logic [7:0]        ee_d;
    logic [HOLD_W-1:0] hold;

    assign busy = stream_on | ee_pend | (hold != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            stream_on  <= 1'b0;
            stream_idx <= '0;
            ee_pend    <= 1'b0;
            hold       <= '0;
            page       <= '0;
            ee_a       <= '0;
            ee_d       <= '0;
        end else begin
            ee_pend <= 1'b0;
            if (stream_on) begin
                stream_idx <= stream_idx + 1'b1;
                if (stream_idx == LAST_IDX) begin
                    stream_on <= 1'b0;
                    hold      <= HOLD_LD;
                end
            end else if (ee_pend) begin
                hold <= HOLD_LD;
            end else if (hold != '0) begin
                hold <= hold - 1'b1;
            end
            if (pw_go) begin
                stream_on  <= 1'b1;
                stream_idx <= '0;
                page       <= pw_page;
            end
            if (ee_go) begin
                ee_pend <= 1'b1;
                ee_a    <= ee_addr;
                ee_d    <= ee_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_wr    <= 1'b0;
            mem_sel   <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_wr    <= stream_on | ee_pend;
            mem_sel   <= ee_pend;
            mem_addr  <= ee_pend ? ee_a : {page, stream_idx};
            mem_wdata <= ee_pend ? {8'h00, ee_d} : stream_word;
        end
    end

endmodule

// File: rtl/spi_prog_target.sv
module spi_prog_target
    import spi_prog_pkg::*;
#(
    parameter int PAGE_WORDS = 128,
    parameter int BUSY_CYC   = 16,
    localparam int OFF_W  = $clog2(PAGE_WORDS),
    localparam int PAGE_W = ADDR_W - OFF_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sess_en,
    input  logic        sck,
    input  logic        mosi,
    output logic        miso,
    output logic        busy,
    output logic        mem_wr,
    output logic        mem_sel,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        rd_en,
    output logic [15:0] rd_addr,
    input  logic [15:0] rd_data
);
    logic              sck_fall, byte_done;
    logic [1:0]        done_idx, byte_idx;
    logic [7:0]        rx_byte, tx_byte;
    logic              pw_go, ee_go;
    logic [PAGE_W-1:0] pw_page;
    logic [15:0]       ee_addr;
    logic [7:0]        ee_data;
    logic [OFF_W-1:0]  stream_idx;
    word_t             stream_word;

    spi_prog_shifter u_shift (
        .clk, .rst, .sess_en, .sck, .mosi, .tx_byte,
        .miso, .sck_fall, .byte_done, .done_idx, .byte_idx, .rx_byte
    );

    spi_prog_decoder #(.PAGE_WORDS(PAGE_WORDS)) u_dec (
        .clk, .rst, .sess_en, .byte_done, .done_idx, .byte_idx, .rx_byte,
        .rd_data, .busy, .stream_idx, .tx_byte, .rd_en, .rd_addr,
        .pw_go, .pw_page, .ee_go, .ee_addr, .ee_data, .stream_word
    );

    spi_prog_commit #(.PAGE_WORDS(PAGE_WORDS), .BUSY_CYC(BUSY_CYC)) u_commit (
        .clk, .rst, .pw_go, .pw_page, .ee_go, .ee_addr, .ee_data,
        .stream_word, .stream_idx, .busy, .mem_wr, .mem_sel, .mem_addr, .mem_wdata
    );

endmodule

// File: rtl/spi_prog_target_chk.sv
module spi_prog_target_chk (
    input logic        clk,
    input logic        rst,
    input logic        sess_en,
    input logic        miso,
    input logic        sck_fall,
    input logic        busy,
    input logic        mem_wr,
    input logic        mem_sel,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        rd_en
);
    AST_IDLE_MISO: assert property (@(posedge clk) disable iff (rst)
        !sess_en |=> !miso); // R1

    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(miso) |-> ($past(sck_fall) || !$past(sess_en))); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_sel && $past(mem_wr) && !$past(mem_sel))
        |-> (mem_addr == $past(mem_addr) + 16'd1)); // R8

    AST_EE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_sel) |-> (mem_wdata[15:8] == 8'h00)); // R9

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en); // R10

    AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(busy)); // R11
endmodule

bind spi_prog_target spi_prog_target_chk u_chk (
    .clk(clk), .rst(rst), .sess_en(sess_en), .miso(miso), .sck_fall(sck_fall),
    .busy(busy), .mem_wr(mem_wr), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rd_en(rd_en)
);

// File: tb/spi_prog_target_bench.sv
`timescale 1ns/1ps
module spi_prog_target_bench;
    localparam int BUSY = 400;
    localparam int HALF = 5;
    localparam int PW   = 128;

    logic clk = 0, rst = 1, sess_en = 0, sck = 0, mosi = 0;
    logic miso, busy, mem_wr, mem_sel, rd_en;
    logic [15:0] mem_addr, mem_wdata, rd_addr, rd_data;

    always #4 clk = ~clk;

    spi_prog_target #(.PAGE_WORDS(PW), .BUSY_CYC(BUSY)) u_spi_prog_target (
        .clk, .rst, .sess_en, .sck, .mosi, .miso, .busy, .mem_wr, .mem_sel,
        .mem_addr, .mem_wdata, .rd_en, .rd_addr, .rd_data
    );

    int n_tests = 0, n_fail = 0;

    function automatic logic [15:0] init_val(input int i);
        return 16'((i * 499) + 66);
    endfunction
    function automatic logic [15:0] pat(input int i);
        return 16'((i * 2823) ^ 16'hC35A);
    endfunction

    logic [15:0] fl [1024];
    initial for (int i = 0; i < 1024; i++) fl[i] = init_val(i);
    always @(posedge clk) begin
        if (rd_en) rd_data <= fl[rd_addr[9:0]];
        if (mem_wr && !mem_sel) fl[mem_addr[9:0]] <= mem_wdata;
    end

    int fw_cnt = 0, ee_cnt = 0, rd_cnt = 0, busy_cnt = 0, cap_n = 0;
    logic [15:0] cap_addr [256];
    logic [15:0] cap_data [256];
    logic [15:0] ee_addr_c, ee_data_c, last_rd;
    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (rd_en) begin rd_cnt++; last_rd = rd_addr; end
        if (mem_wr && !mem_sel) begin
            fw_cnt++;
            if (cap_n < 256) begin cap_addr[cap_n] = mem_addr; cap_data[cap_n] = mem_wdata; end
            cap_n++;
        end
        if (mem_wr && mem_sel) begin ee_cnt++; ee_addr_c = mem_addr; ee_data_c = mem_wdata; end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic r);
        mosi = b;
        repeat (HALF) @(negedge clk);
        r = miso;
        sck = 1;
        repeat (HALF) @(negedge clk);
        sck = 0;
    endtask

    task automatic instr(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3,
                         output logic [31:0] r);
        logic [31:0] w;
        w = {b0, b1, b2, b3};
        for (int i = 31; i >= 0; i--) send_bit(w[i], r[i]);
        repeat (8) @(negedge clk);
    endtask

    task automatic sess_pulse();
        sess_en = 0;
        repeat (4) @(negedge clk);
        sess_en = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    logic [15:0] pexp [PW];
    logic [31:0] r;
    logic        sb;

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 miso reset", miso, 0);
        chk("R1 busy reset", busy, 0);
        chk("R1 mem_wr reset", mem_wr, 0);
        sess_en = 1;
        repeat (2) @(negedge clk);

        // R4 no effect before enable
        instr(8'h40, 8'h00, 8'h05, 8'hAA, r);
        instr(8'h4C, 8'h00, 8'h80, 8'h00, r);
        instr(8'h20, 8'h00, 8'h03, 8'h00, r);
        wait_idle();
        chk("R4 no write before enable", fw_cnt, 0);
        chk("R4 no read before enable", rd_cnt, 0);
        chk("R4 fourth byte echo", r[7:0], 8'h03);
        chk("R3 first byte zero", r[31:24], 8'h00);
        chk("R3 second byte echo", r[23:16], 8'h20);

        // R5 stray bit breaks alignment until session pulse
        send_bit(1'b0, sb);
        instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
        instr(8'h4C, 8'h00, 8'h00, 8'h00, r);
        wait_idle();
        chk("R5 misaligned enable ignored", fw_cnt, 0);
        sess_pulse();

        // R4 wrong sync byte does not enable
        instr(8'hAC, 8'h55, 8'h00, 8'h00, r);
        chk("R3 echo of second byte", r[15:8], 8'h55);
        instr(8'h4C, 8'h00, 8'h00, 8'h00, r);
        wait_idle();
        chk("R4 bad sync no enable", fw_cnt, 0);

        // R3 enable with echo
        instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk("R3 sync echo", r[15:8], 8'h53);
        chk("R3 opcode echo", r[23:16], 8'hAC);
        chk("R3 enable first byte", r[31:24], 8'h00);

        // R6 R7 full page load, low before high
        for (int i = 0; i < PW; i++) begin
            pexp[i] = pat(i);
            instr(8'h40, 8'h00, 8'(i), pexp[i][7:0], r);
            instr(8'h48, 8'h00, 8'(i), pexp[i][15:8], r);
        end
        instr(8'h48, 8'h00, 8'd5, 8'hEE, r);          // R7 no pending low
        instr(8'h40, 8'h00, 8'd6, 8'h77, r);          // R6
        pexp[6][7:0] = 8'h77;
        instr(8'h48, 8'h00, 8'd7, 8'h99, r);          // R7 offset mismatch
        instr(8'h48, 8'h00, 8'd6, 8'h55, r);          // R7 pending cleared
        instr(8'h40, 8'h00, 8'd8, 8'h12, r);
        instr(8'h48, 8'h00, 8'd8, 8'h34, r);          // R7 accepted
        pexp[8] = 16'h3412;

        // R8 R11 commit page 3, second commit while busy
        cap_n = 0; fw_cnt = 0; busy_cnt = 0;
        instr(8'h4C, 8'h01, 8'h80, 8'h00, r);
        instr(8'h4C, 8'h00, 8'h00, 8'h00, r);
        wait_idle();
        chk("R11 commit during busy ignored", fw_cnt, PW);
        chk("R11 page busy length", busy_cnt, PW + BUSY);
        for (int i = 0; i < PW; i++) begin
            chk("R8 stream address", cap_addr[i], 16'h0180 + 16'(i));
            chk("R8 stream data", cap_data[i], pexp[i]);
        end

        // R10 reads
        for (int j = 0; j < 16; j++) begin
            instr(8'h20, 8'h01, 8'h80 + 8'(j), 8'h00, r);
            chk("R10 read low", r[7:0], pexp[j][7:0]);
            instr(8'h28, 8'h01, 8'h80 + 8'(j), 8'h00, r);
            chk("R10 read high", r[7:0], pexp[j][15:8]);
        end
        chk("R10 read address", last_rd, 16'h018F);
        instr(8'h28, 8'h00, 8'h10, 8'h00, r);
        chk("R11 page 0 untouched", r[7:0], init_val(16)>>8);
        chk("R10 third byte echo", r[15:8], 8'h00);

        // R9 R11 EEPROM writes
        busy_cnt = 0;
        instr(8'hC0, 8'h0A, 8'h5B, 8'hC3, r);
        instr(8'hC0, 8'h00, 8'h01, 8'h3C, r);
        wait_idle();
        chk("R9 ee count", ee_cnt, 1);
        chk("R9 ee addr", ee_addr_c, 16'h0A5B);
        chk("R9 ee data", ee_data_c, 16'h00C3);
        chk("R11 ee busy length", busy_cnt, 1 + BUSY);
        instr(8'hC0, 8'h0A, 8'h5B, 8'hF0, r);
        wait_idle();
        chk("R9 ee replace", ee_data_c, 16'h00F0);
        chk("R9 ee count 2", ee_cnt, 2);

        // R1 session drop clears enable
        sess_pulse();
        fw_cnt = 0;
        instr(8'h4C, 8'h00, 8'h00, 8'h00, r);
        wait_idle();
        chk("R1 enable cleared by session drop", fw_cnt, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule